// File: doc/BRIEF.md
# Terminal Basic-Rate Line Activation State Machine

This block sequences the terminal side of a basic-rate S/T line through deactivation, activation and test. A line decoder upstream delivers per-frame flags that say which line signal is being received: INFO 0, INFO 2, INFO 4, some other non-idle signal, or loss of framing. Layer 2 sends a 4-bit command once per frame over a command/indication channel. The block answers with the INFO signal the transmitter should send and a 4-bit indication code for layer 2.

Commands and line flags are sampled only on a one-cycle frame strobe, so the state, and with it both outputs, changes at most once per frame. A command is held until it has taken effect. Reset and the two pulse test modes can be entered from any state. The activation requests of both priority classes and the loop request are accepted from the deactivated state. Both outputs are decoded from the current state alone.

Top module: `te_l1_act`

## Requirements
- R1: The state and both outputs change only on a clock edge where `frame_tick` is high. Commands and line flags presented in other cycles have no effect.
- R2: While `rst_n` is low, and after its release until the first frame, the block is in the reset state: `ind` = 0001 and `tx_info` = 000 (INFO 0).
- R3: From any state, the following commands are applied with top priority:
  - command 0001 enters the reset state (`ind` 0001, `tx_info` 000);
  - command 0010 enters the single-pulse test mode (`tx_info` 100, `ind` 0010);
  - command 0011 enters the continuous-pulse test mode (`tx_info` 101, 48 alternating pulses per frame, `ind` 0010).

  The reset state and both test modes leave only on command 1111, which goes to pending deactivation.
- R4: Pending deactivation transmits INFO 0 (`tx_info` 000) and indicates 0000. It is entered when INFO 0 is received in the unsynchronized, synchronized, activated or lost-framing state. It is also entered on command 1111 from the pending-activation state.
- R5: In pending deactivation, command 1000 (priority class 8) or 1001 (priority class 10) enters pending activation. This happens only while no non-INFO-0 line signal is received. Pending activation transmits INFO 1 (`tx_info` 001) and indicates 0111.
- R6: In pending deactivation or pending activation, any received signal other than INFO 0 (INFO 2, INFO 4 or other) enters the unsynchronized state. This takes precedence over the commands. The unsynchronized state transmits INFO 0 and indicates 0100.
- R7: Line signals move the state as follows; the synchronized and activated states both transmit INFO 3 (`tx_info` 011):
  - from the unsynchronized or lost-framing state, INFO 2 enters the synchronized state (`ind` 1000);
  - from the unsynchronized or lost-framing state, INFO 4 enters the activated state (`ind` 1100);
  - from the activated state, INFO 2 returns to the synchronized state;
  - from the synchronized state, INFO 4 enters the activated state.
- R8: Loss of framing in the synchronized or activated state enters the lost-framing state. That state transmits INFO 0 and indicates receiver-not-synchronous, 0100.
- R9: In pending deactivation, command 1010 (loop request) enters the loop state, which transmits INFO 3 and indicates 1110. Command 1111 returns it to pending deactivation.
- R10: A command with no transition from the current state has no effect. This includes timing 0000, undefined codes and activation requests outside pending deactivation. A line flag with no such transition also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame strobe; inputs are sampled only here |
| cmd | input | 4 | Command code from layer 2 |
| rx_info0 | input | 1 | INFO 0 received |
| rx_info2 | input | 1 | INFO 2 received |
| rx_info4 | input | 1 | INFO 4 received |
| rx_other | input | 1 | Non-idle signal other than INFO 2/4 received |
| rx_lost | input | 1 | Loss of framing |
| tx_info | output | 3 | Signal to transmit: 000 INFO 0, 001 INFO 1, 011 INFO 3, 100 single pulses, 101 continuous pulses |
| ind | output | 4 | Indication code to layer 2 |

## Verification
The assertions assume that the line decoder raises at most one of the five line flags in any frame. The bench drives only the six patterns that respect this: none, or exactly one flag. They also assume that `frame_tick` is a single-cycle pulse. The bench raises it for one cycle per frame and changes commands and flags only at the falling clock edge. Every state is reached by a known command path. The bench then applies every command code, including an undefined one, against every line pattern.

// File: rtl/te_l1_act.sv
module te_l1_act (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic [3:0] cmd,
  input  logic       rx_info0,
  input  logic       rx_info2,
  input  logic       rx_info4,
  input  logic       rx_other,
  input  logic       rx_lost,
  output logic [2:0] tx_info,
  output logic [3:0] ind
);
  localparam logic [3:0] C_TIM = 4'b0000, C_RES = 4'b0001, C_SSP = 4'b0010,
                         C_SCP = 4'b0011, C_AR8 = 4'b1000, C_AR10 = 4'b1001,
                         C_ARL = 4'b1010, C_DI = 4'b1111;
  localparam logic [3:0] I_DR = 4'b0000, I_RES = 4'b0001, I_TMA = 4'b0010,
                         I_RSY = 4'b0100, I_PU = 4'b0111, I_AR = 4'b1000,
                         I_AI = 4'b1100, I_AIL = 4'b1110;
  localparam logic [2:0] T_I0 = 3'd0, T_I1 = 3'd1, T_I3 = 3'd3,
                         T_SGL = 3'd4, T_CONT = 3'd5;

  typedef enum logic [3:0] {
    S_RST, S_DEACT, S_PEND, S_UNSYNC, S_SYNC, S_ACT, S_LOST,
    S_TSGL, S_TCONT, S_LOOP
  } st_t;

  st_t state, nxt;
  logic sig_up, uncond;

  assign sig_up = rx_info2 | rx_info4 | rx_other;
  assign uncond = (cmd == C_RES) || (cmd == C_SSP) || (cmd == C_SCP);

  always_comb begin
    nxt = state;
    if (cmd == C_RES) nxt = S_RST;
    else if (cmd == C_SSP) nxt = S_TSGL;
    else if (cmd == C_SCP) nxt = S_TCONT;
    else begin
      case (state)
        S_RST, S_TSGL, S_TCONT, S_LOOP:
          if (cmd == C_DI) nxt = S_DEACT;
        S_DEACT:
          if (sig_up) nxt = S_UNSYNC;
          else if (cmd == C_AR8 || cmd == C_AR10) nxt = S_PEND;
          else if (cmd == C_ARL) nxt = S_LOOP;
        S_PEND:
          if (sig_up) nxt = S_UNSYNC;
          else if (cmd == C_DI) nxt = S_DEACT;
        S_UNSYNC, S_LOST:
          if (rx_info4) nxt = S_ACT;
          else if (rx_info2) nxt = S_SYNC;
          else if (rx_info0) nxt = S_DEACT;
        S_SYNC:
          if (rx_info0) nxt = S_DEACT;
          else if (rx_lost) nxt = S_LOST;
          else if (rx_info4) nxt = S_ACT;
        S_ACT:
          if (rx_info0) nxt = S_DEACT;
          else if (rx_lost) nxt = S_LOST;
          else if (rx_info2) nxt = S_SYNC;
        default: nxt = S_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_RST;
    else if (frame_tick) state <= nxt;

  always_comb begin
    case (state)
      S_RST:    begin ind = I_RES; tx_info = T_I0;   end
      S_DEACT:  begin ind = I_DR;  tx_info = T_I0;   end
      S_PEND:   begin ind = I_PU;  tx_info = T_I1;   end
      S_UNSYNC: begin ind = I_RSY; tx_info = T_I0;   end
      S_SYNC:   begin ind = I_AR;  tx_info = T_I3;   end
      S_ACT:    begin ind = I_AI;  tx_info = T_I3;   end
      S_LOST:   begin ind = I_RSY; tx_info = T_I0;   end
      S_TSGL:   begin ind = I_TMA; tx_info = T_SGL;  end
      S_TCONT:  begin ind = I_TMA; tx_info = T_CONT; end
      S_LOOP:   begin ind = I_AIL; tx_info = T_I3;   end
      default:  begin ind = I_RES; tx_info = T_I0;   end
    endcase
  end

  a_r1_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(state));
  a_r3_reset_any_state: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && cmd == C_RES |=> ind == I_RES && tx_info == T_I0);
  a_r3_cont_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && cmd == C_SCP |=> tx_info == T_CONT);
  a_r6_wake_on_signal: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && state == S_DEACT && sig_up && !uncond |=> state == S_UNSYNC);
  a_r8_lost_framing: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && state == S_ACT && rx_lost && !rx_info0 && !uncond |=> ind == I_RSY);
  a_r10_line_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> $onehot0({rx_info0, rx_info2, rx_info4, rx_other, rx_lost}));
endmodule

// File: tb/te_l1_act_test.sv
module te_l1_act_test;
  logic clk = 0, rst_n = 0, frame_tick = 0;
  logic [3:0] cmd = 0;
  logic rx_info0 = 0, rx_info2 = 0, rx_info4 = 0, rx_other = 0, rx_lost = 0;
  logic [2:0] tx_info;
  logic [3:0] ind;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  te_l1_act uut (.clk, .rst_n, .frame_tick, .cmd, .rx_info0, .rx_info2,
                 .rx_info4, .rx_other, .rx_lost, .tx_info, .ind);

  // model states: 0 rst,1 deact,2 pend,3 unsync,4 sync,5 act,6 lost,7 sgl,8 cont,9 loop
  // line patterns: 0 none,1 info0,2 info2,3 info4,4 other,5 lost
  function automatic int nx(int s, logic [3:0] c, int p);
    bit up = (p == 2) || (p == 3) || (p == 4);
    if (c == 4'd1) return 0;
    if (c == 4'd2) return 7;
    if (c == 4'd3) return 8;
    case (s)
      0, 7, 8, 9: return (c == 4'd15) ? 1 : s;
      1: if (up) return 3; else if (c == 4'd8 || c == 4'd9) return 2;
         else if (c == 4'd10) return 9; else return 1;
      2: if (up) return 3; else if (c == 4'd15) return 1; else return 2;
      3, 6: if (p == 3) return 5; else if (p == 2) return 4;
            else if (p == 1) return 1; else return s;
      4: if (p == 1) return 1; else if (p == 5) return 6; else if (p == 3) return 5; else return 4;
      5: if (p == 1) return 1; else if (p == 5) return 6; else if (p == 2) return 4; else return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] ind_of(int s);
    case (s)
      0: return 4'b0001; 1: return 4'b0000; 2: return 4'b0111; 3: return 4'b0100;
      4: return 4'b1000; 5: return 4'b1100; 6: return 4'b0100; 7, 8: return 4'b0010;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [2:0] tx_of(int s);
    case (s)
      2: return 3'd1; 4, 5, 9: return 3'd3; 7: return 3'd4; 8: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag(int s, logic [3:0] c, int n);
    if (c == 4'd1 || c == 4'd2 || c == 4'd3) return "R3";
    if (n == s) return "R10";
    case (n)
      1: return "R4"; 2: return "R5"; 3: return "R6"; 4, 5: return "R7";
      6: return "R8"; 9: return "R9"; default: return "R3";
    endcase
  endfunction

  task automatic set_line(int p);
    rx_info0 = (p == 1); rx_info2 = (p == 2); rx_info4 = (p == 3);
    rx_other = (p == 4); rx_lost = (p == 5);
  endtask

  task automatic frame(logic [3:0] c, int p);
    @(negedge clk); cmd = c; set_line(p); frame_tick = 1;
    @(negedge clk); frame_tick = 0; cmd = 4'd0; set_line(0);
  endtask

  task automatic check(int s, string r);
    checks++;
    if (ind !== ind_of(s) || tx_info !== tx_of(s)) begin
      fails++;
      $display("FAIL %s: ind=%b tx=%0d expected ind=%b tx=%0d", r, ind, tx_info, ind_of(s), tx_of(s));
    end
  endtask

  task automatic go(int s);
    frame(4'd1, 0);
    case (s)
      1: frame(4'd15, 0);
      2: begin frame(4'd15, 0); frame(4'd8, 0); end
      3: begin frame(4'd15, 0); frame(4'd0, 4); end
      4: begin frame(4'd15, 0); frame(4'd0, 4); frame(4'd0, 2); end
      5: begin frame(4'd15, 0); frame(4'd0, 4); frame(4'd0, 3); end
      6: begin frame(4'd15, 0); frame(4'd0, 4); frame(4'd0, 3); frame(4'd0, 5); end
      7: frame(4'd2, 0);
      8: frame(4'd3, 0);
      9: begin frame(4'd15, 0); frame(4'd10, 0); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] cmds [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd15, 4'd5};
    repeat (3) @(negedge clk);
    check(0, "R2");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(0, "R2");
    // R1: strobe absent, commands and line flags ignored
    go(5); check(5, "R7");
    @(negedge clk); cmd = 4'd1; rx_info0 = 1;
    repeat (3) @(negedge clk);
    check(5, "R1");
    cmd = 4'd3; rx_info0 = 0; rx_lost = 1;
    @(negedge clk); check(5, "R1");
    cmd = 0; rx_lost = 0;
    // exhaustive: every state x every command x every line pattern
    for (int s = 0; s < 10; s++)
      for (int ci = 0; ci < 9; ci++)
        for (int p = 0; p < 6; p++) begin
          int n;
          go(s);
          check(s, "R3");
          n = nx(s, cmds[ci], p);
          frame(cmds[ci], p);
          check(n, tag(s, cmds[ci], n));
        end
    // reset mid-activation returns to reset state
    go(5); rst_n = 0; @(negedge clk); check(0, "R2"); rst_n = 1; @(negedge clk); check(0, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule